// File: doc/BRIEF.md
# Quad Converter Serial Register Front-End

This block is the digital side of a four-channel 12-bit digital-to-analog converter. A serial host streams 16-bit frames into a shift register. The shift register advances on every rising edge of the logical OR of a select line and a serial clock. Each frame carries a 2-bit channel address, two don't-care bits and a 12-bit code. While the update strobe is held low, the addressed channel register is open and follows the code field of the shift register. While the strobe is high, every channel holds its value.

A separate active-low preset input forces all four channel codes to one of two preset values. A select input chooses between them: zero-scale 0x000 or mid-scale 0x800. The preset acts on the outputs at once and is kept by every closed channel after it is released. It never disturbs the shift register.

The serial inputs are sampled on the core clock. A rising edge of the OR is detected between two consecutive samples, so each serial level must be held for at least two core cycles. The open-channel path and the preset override are combinational onto the code outputs. The channel storage is updated on the core clock.

Top module: `quad_dac_frontend`

## Requirements
- R1: The last 16 bits shifted in form the frame, oldest bit first. Frame bits 15:14 are the channel address, bits 13:12 are ignored, and bits 11:0 are the code, most significant bit first.
- R2: The shift register moves by exactly one bit on each rising edge of (ser_sel OR ser_clk), taking ser_data. Either input may act as the shift clock while the other is held low. With no such edge, it keeps its contents.
- R3: If ser_sel rises while ser_clk is low, one extra bit is shifted. After this, the frame fields are read from the shifted-on contents.
- R4: Address 00 selects code_a, 01 selects code_b, 10 selects code_c and 11 selects code_d.
- R5: While upd_n is high and preset_n is high, all four channel codes hold their values.
- R6: While upd_n is low, the addressed channel follows the shift register's code field, including while shifting. Every channel addressed along the way keeps the last code it saw, and unaddressed channels hold.
- R7: While preset_n is low, all four codes read 0x000 if preset_mid is low, or 0x800 if it is high. After preset_n returns high, closed channels keep that value.
- R8: Preset does not change the shift register contents.
- R9: When preset_n and upd_n are both low, the preset value wins on every channel.
- R10: After rst_n, the shift register is all zeros and all four codes are 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that samples all serial and control inputs |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| ser_sel | input | 1 | Select line, ORed with ser_clk to form the shift clock |
| ser_clk | input | 1 | Serial clock, ORed with ser_sel to form the shift clock |
| ser_data | input | 1 | Serial data bit |
| upd_n | input | 1 | Active-low update strobe; low opens the addressed channel |
| preset_n | input | 1 | Active-low preset of all channel codes |
| preset_mid | input | 1 | Preset choice: 0 gives 0x000, 1 gives 0x800 |
| code_a | output | 12 | Channel A code |
| code_b | output | 12 | Channel B code |
| code_c | output | 12 | Channel C code |
| code_d | output | 12 | Channel D code |

## Verification
The bench uses the default build: 12-bit codes, two pad bits and four channels. This makes the state small enough to sweep a walking-one code across every bit position on every address, plus solid patterns. The same build also covers both preset codes, the extra-shift hazard with either data value left on the line, and swapping the roles of the select line and the serial clock. Streaming a frame while the strobe is open drives the addressed channel through every address that passes through the top bits. The bench predicts the resulting corruption of each channel from its own bit-level model.

// File: rtl/quad_dac_frontend_pkg.sv
package quad_dac_frontend_pkg;

    localparam int unsigned DEF_CODE_W = 12;
    localparam int unsigned DEF_PAD_W  = 2;
    localparam int unsigned NUM_CH     = 4;

    // Preset value: MSB set for mid-scale, all zero otherwise.
    function automatic logic [DEF_CODE_W-1:0] preset_word(input logic mid);
        preset_word = {mid, {(DEF_CODE_W-1){1'b0}}};
    endfunction

endpackage

// File: rtl/quad_dac_shift.sv
module quad_dac_shift #(
    parameter int unsigned FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_sel,
    input  logic               ser_clk,
    input  logic               ser_data,
    output logic [FRAME_W-1:0] frame_o
);

    typedef struct packed {
        logic               gate;
        logic [FRAME_W-1:0] sr;
    } shift_st_t;

    shift_st_t s_d, s_q;
    logic      gate_now;
    logic      step;

    always_comb begin
        gate_now = ser_sel | ser_clk;
        step     = gate_now & ~s_q.gate;
        s_d      = s_q;
        s_d.gate = gate_now;
        if (step) begin
            s_d.sr = {s_q.sr[FRAME_W-2:0], ser_data};
        end
    end

    // Gate history resets high so an idle-high line gives no edge at start.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{gate: 1'b1, sr: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign frame_o = s_q.sr;

    // R2: no edge of the OR leaves the register untouched
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !((ser_sel | ser_clk) && !s_q.gate) |=> $stable(s_q.sr));

    // R2: an edge moves the register by one bit, taking the serial data
    p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((ser_sel | ser_clk) && !s_q.gate) |=>
            (s_q.sr == {$past(s_q.sr[FRAME_W-2:0]), $past(ser_data)}));

endmodule

// File: rtl/quad_dac_bank.sv
module quad_dac_bank #(
    parameter int unsigned NCH    = 4,
    parameter int unsigned CODE_W = 12,
    parameter int unsigned ADDR_W = $clog2(NCH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         upd_n,
    input  logic                         preset_n,
    input  logic                         preset_mid,
    input  logic [ADDR_W-1:0]            addr_i,
    input  logic [CODE_W-1:0]            code_i,
    output logic [NCH-1:0][CODE_W-1:0]   code_o
);

    typedef struct packed {
        logic [NCH-1:0][CODE_W-1:0] ch;
    } bank_st_t;

    bank_st_t          b_d, b_q;
    logic [NCH-1:0]    open;
    logic [CODE_W-1:0] preset_val;

    assign preset_val = {preset_mid, {(CODE_W-1){1'b0}}};

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_ch
            assign open[c] = ~upd_n & (addr_i == ADDR_W'(c));
            // Preset overrides the open path, which overrides storage.
            assign code_o[c] = !preset_n ? preset_val :
                               open[c]   ? code_i     : b_q.ch[c];

            // R6: a channel not addressed while open keeps its code
            p_other_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (preset_n && !upd_n && (addr_i != ADDR_W'(c))) |=> $stable(b_q.ch[c]));

            // R7: preset leaves the selected preset code in storage
            p_preset_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
                !preset_n |=> (b_q.ch[c] == {$past(preset_mid), {(CODE_W-1){1'b0}}}));
        end
    endgenerate

    always_comb begin
        b_d = b_q;
        for (int k = 0; k < NCH; k++) begin
            if (!preset_n) begin
                b_d.ch[k] = preset_val;
            end else if (open[k]) begin
                b_d.ch[k] = code_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    // R5: closed strobe and no preset hold every channel
    p_hold_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (preset_n && upd_n) |=> $stable(b_q));

endmodule

// File: rtl/quad_dac_frontend.sv
module quad_dac_frontend #(
    parameter int unsigned CODE_W = quad_dac_frontend_pkg::DEF_CODE_W,
    parameter int unsigned PAD_W  = quad_dac_frontend_pkg::DEF_PAD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_sel,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              upd_n,
    input  logic              preset_n,
    input  logic              preset_mid,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b,
    output logic [CODE_W-1:0] code_c,
    output logic [CODE_W-1:0] code_d
);

    localparam int unsigned NCH     = quad_dac_frontend_pkg::NUM_CH;
    localparam int unsigned ADDR_W  = $clog2(NCH);
    localparam int unsigned FRAME_W = ADDR_W + PAD_W + CODE_W;

    logic [FRAME_W-1:0]          frame;
    logic [NCH-1:0][CODE_W-1:0]  codes;
    logic                        pad_unused;

    quad_dac_shift #(
        .FRAME_W (FRAME_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_sel  (ser_sel),
        .ser_clk  (ser_clk),
        .ser_data (ser_data),
        .frame_o  (frame)
    );

    // Pad bits carry no meaning.
    assign pad_unused = ^frame[CODE_W +: PAD_W];

    quad_dac_bank #(
        .NCH    (NCH),
        .CODE_W (CODE_W),
        .ADDR_W (ADDR_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_n      (upd_n),
        .preset_n   (preset_n),
        .preset_mid (preset_mid),
        .addr_i     (frame[FRAME_W-1 -: ADDR_W]),
        .code_i     (frame[CODE_W-1:0]),
        .code_o     (codes)
    );

    assign code_a = codes[0];
    assign code_b = codes[1];
    assign code_c = codes[2];
    assign code_d = codes[3];

    // R8: preset with no shift edge leaves the frame untouched
    p_preset_keeps_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!preset_n && !ser_sel && !ser_clk) |=> $stable(frame));

endmodule

// File: tb/quad_dac_frontend_test.sv
module quad_dac_frontend_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_sel = 1'b1, ser_clk = 1'b1, ser_data = 1'b0;
    logic upd_n = 1'b1, preset_n = 1'b1, preset_mid = 1'b0;
    logic [11:0] code_a, code_b, code_c, code_d;
    logic [11:0] outs [4];

    int checks = 0;
    int errors = 0;

    logic [15:0] m_sh = '0;
    logic [11:0] m_ch [4] = '{default: '0};

    always #10 clk = ~clk;   // 50 MHz

    quad_dac_frontend uut (
        .clk(clk), .rst_n(rst_n), .ser_sel(ser_sel), .ser_clk(ser_clk),
        .ser_data(ser_data), .upd_n(upd_n), .preset_n(preset_n),
        .preset_mid(preset_mid), .code_a(code_a), .code_b(code_b),
        .code_c(code_c), .code_d(code_d)
    );

    assign outs[0] = code_a;
    assign outs[1] = code_b;
    assign outs[2] = code_c;
    assign outs[3] = code_d;

    function automatic logic [11:0] pval(input logic mid);
        return mid ? 12'h800 : 12'h000;
    endfunction

    function automatic logic [11:0] expv(input int c);
        if (!preset_n) return pval(preset_mid);
        if (!upd_n && m_sh[15:14] == 2'(c)) return m_sh[11:0];
        return m_ch[c];
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        if (!preset_n) begin
            for (int c = 0; c < 4; c++) m_ch[c] = pval(preset_mid);
        end else if (!upd_n) begin
            m_ch[m_sh[15:14]] = m_sh[11:0];
        end
    endtask

    task automatic check_all(input string req);
        for (int c = 0; c < 4; c++) begin
            checks++;
            if (outs[c] !== expv(c)) begin
                errors++;
                $display("FAIL %s ch%0d actual=%h expected=%h", req, c, outs[c], expv(c));
            end
        end
    endtask

    task automatic clk_bit(input logic b);
        ser_clk = 1'b0; ser_data = b; tick(2);
        ser_clk = 1'b1; m_sh = {m_sh[14:0], b}; tick(2);
    endtask

    // Pad bits are sent as 2'b10 to show they are ignored (R1).
    task automatic send_frame(input logic [1:0] a, input logic [11:0] code);
        logic [15:0] w;
        w = {a, 2'b10, code};
        ser_sel = 1'b0; tick(2);
        for (int i = 15; i >= 0; i--) clk_bit(w[i]);
        ser_sel = 1'b1; tick(2);
    endtask

    // Select line ends the frame while the serial clock is low (R3).
    task automatic send_spur(input logic [1:0] a, input logic [11:0] code, input logic d);
        logic [15:0] w;
        w = {a, 2'b01, code};
        ser_sel = 1'b0; tick(2);
        for (int i = 15; i >= 0; i--) clk_bit(w[i]);
        ser_clk = 1'b0; ser_data = d; tick(2);
        ser_sel = 1'b1; m_sh = {m_sh[14:0], d}; tick(2);
        ser_clk = 1'b1; tick(2);
    endtask

    // Select line used as the shift clock, serial clock held low (R2).
    task automatic send_swap(input logic [1:0] a, input logic [11:0] code);
        logic [15:0] w;
        w = {a, 2'b11, code};
        ser_clk = 1'b0; tick(2);
        for (int i = 15; i >= 0; i--) begin
            ser_sel = 1'b0; ser_data = w[i]; tick(2);
            ser_sel = 1'b1; m_sh = {m_sh[14:0], w[i]}; tick(2);
        end
        ser_clk = 1'b1; tick(2);
    endtask

    task automatic pulse_load();
        upd_n = 1'b0; tick(2);
        upd_n = 1'b1; tick(2);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        check_all("R10 reset codes");
        pulse_load();
        check_all("R10 zero shift register");

        // Sweep a walking one on every address.
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 12; b++) begin
                send_frame(2'(a), 12'(1) << b);
                check_all("R5 closed strobe hold");
                pulse_load();
                check_all("R1 R4 walking one");
            end
            send_frame(2'(a), 12'hFFF ^ 12'(a * 12'h111));
            pulse_load();
            check_all("R1 R4 solid pattern");
        end

        send_swap(2'd2, 12'h3C7);
        pulse_load();
        check_all("R2 select as clock");
        send_swap(2'd1, 12'h0E1);
        pulse_load();
        check_all("R2 select as clock");

        send_spur(2'd1, 12'h5A5, 1'b1);
        pulse_load();
        check_all("R3 extra shift one");
        send_spur(2'd3, 12'h0F0, 1'b0);
        pulse_load();
        check_all("R3 extra shift zero");

        for (int m = 0; m < 2; m++) begin
            preset_mid = m[0];
            preset_n = 1'b0; tick(2);
            check_all("R7 preset active");
            preset_n = 1'b1; tick(2);
            check_all("R7 preset kept");
        end

        send_frame(2'd2, 12'h777);
        preset_mid = 1'b0;
        preset_n = 1'b0; tick(2);
        preset_n = 1'b1; tick(2);
        check_all("R7 preset before load");
        pulse_load();
        check_all("R8 frame survives preset");

        upd_n = 1'b0; tick(2);
        preset_mid = 1'b1;
        preset_n = 1'b0; tick(2);
        check_all("R9 preset over open path");
        preset_n = 1'b1; tick(2);
        check_all("R6 open after preset");
        upd_n = 1'b1; tick(2);
        check_all("R9 closed channels keep preset");

        send_frame(2'd0, 12'hFFF);
        pulse_load();
        upd_n = 1'b0; tick(2);
        send_frame(2'd3, 12'h123);
        check_all("R6 streaming open");
        upd_n = 1'b1; tick(2);
        check_all("R6 streaming corruption");
        upd_n = 1'b0; tick(2);
        send_frame(2'd1, 12'hC3C);
        upd_n = 1'b1; tick(2);
        check_all("R6 streaming corruption");

        summary();
        $finish;
    end

endmodule